// File: doc/BRIEF.md
# Dual-Width Compare Flag Unit

This unit evaluates a compare for a processor whose registers are 24 bits wide. It subtracts a source operand from a destination operand. From that one difference it derives two sets of condition flags in parallel. The narrow set judges the low 16 bits. The wide set judges all 24 bits. The difference itself is discarded.

The source can be a data register value, an address register value, or an immediate built from instruction fields. A 16-bit immediate is widened in one of two ways, chosen by the kind of register being compared. A 24-bit immediate is assembled from a 16-bit field and an 8-bit extension byte. The eight flags are placed into a status-word image at bit positions set by parameters. A matching write-enable mask is produced alongside them. Both are registered, so a compare strobed in one cycle is visible after the next rising edge.

Top module: `cmpflag_unit`

## Requirements
- R1: The difference is dst_val minus the source, modulo 2^24. The narrow zero flag is set when the low 16 bits of the difference are zero. The wide zero flag is set when all 24 bits are zero.
- R2: The narrow negative flag equals bit 15 of the difference. The wide negative flag equals bit 23.
- R3: The narrow carry flag is set when the unsigned low 16 bits of the source exceed those of the destination. The wide carry flag is set when the unsigned 24-bit source exceeds the 24-bit destination.
- R4: An overflow flag is set when destination and source differ in sign, and the difference's sign also differs from the destination's sign. The narrow flag tests bit 15 and the wide flag tests bit 23.
- R5: src_sel chooses the source operand as follows: 0 selects dreg_val, 1 selects areg_val, 2 selects the 16-bit immediate, and 3 selects the 24-bit immediate.
- R6: The 16-bit immediate is imm_field. It is sign-extended to 24 bits when dst_is_addr is 0 and zero-extended when dst_is_addr is 1.
- R7: The 24-bit immediate is imm_field in bits 23:8 and imm_ext in bits 7:0.
- R8: In the cycle after op_valid is high, flag_we_o has exactly the eight flag positions set. In the cycle after op_valid is low, flag_we_o is zero.
- R9: flags_o takes the new flags in the cycle after op_valid is high. It keeps its value whatever the other inputs do while op_valid is low. Bits outside the eight flag positions are always zero.
- R10: While rst_n is low at a rising edge, flags_o and flag_we_o become zero.
- R11: With the default parameters, the status-word positions are as follows: narrow Z, N, C and V at bits 0, 1, 2 and 3, and wide Z, N, C and V at bits 4, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A compare is presented this cycle |
| src_sel | input | 2 | Source operand form |
| dst_is_addr | input | 1 | The destination is an address register (selects imm16 extension) |
| dst_val | input | 24 | Destination register value |
| dreg_val | input | 24 | Data register source value |
| areg_val | input | 24 | Address register source value |
| imm_field | input | 16 | 16-bit instruction immediate field |
| imm_ext | input | 8 | Extension byte for the 24-bit immediate |
| flags_o | output | 16 | Status-word image holding the eight flags |
| flag_we_o | output | 16 | Write-enable mask for the flag positions |

## Verification
The narrow and wide flag sets are produced in the same cycle from the same difference, and they can disagree. The sweep pairs operands whose low 16 bits match but whose upper bytes differ. It also crosses the 0x7FFF/0x8000 and 0x7FFFFF/0x800000 boundaries. These cases give results where, for example, narrow zero is set while wide zero is clear, or where narrow overflow is set without wide overflow. Every flag of both sets is compared against bench arithmetic for each operand form. An idle cycle with scrambled inputs follows each compare.

// File: rtl/cmpflag_pkg.sv
// Shared types for the dual-width compare flag unit.
package cmpflag_pkg;
    typedef enum logic [1:0] {
        SRC_DREG  = 2'd0,
        SRC_AREG  = 2'd1,
        SRC_IMM16 = 2'd2,
        SRC_IMM24 = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flagset_t;
endpackage

// File: rtl/cmpflag_opsel.sv
// Source operand former.
// Picks a register value or builds an immediate from the instruction fields.
// Assumes REG_W > IMM_W. The extension byte fills the remaining low bits.
module cmpflag_opsel
    import cmpflag_pkg::*;
#(
    parameter int REG_W = 24,
    parameter int IMM_W = 16
) (
    input  src_sel_e           sel,
    input  logic               dst_is_addr,
    input  logic [REG_W-1:0]   dreg_val,
    input  logic [REG_W-1:0]   areg_val,
    input  logic [IMM_W-1:0]   imm_field,
    input  logic [REG_W-IMM_W-1:0] imm_ext,
    output logic [REG_W-1:0]   src
);
    localparam int EXT_W = REG_W - IMM_W;

    // Operand mux: address targets zero-extend imm16, data targets sign-extend it.
    always_comb begin
        unique case (sel)
            SRC_DREG:  src = dreg_val;
            SRC_AREG:  src = areg_val;
            SRC_IMM16: src = dst_is_addr ? {{EXT_W{1'b0}}, imm_field}
                                         : {{EXT_W{imm_field[IMM_W-1]}}, imm_field};
            default:   src = {imm_field, imm_ext};
        endcase
    end
endmodule

// File: rtl/cmpflag_slice.sv
// Flag evaluator for one width.
// Computes Z, N, C (unsigned borrow) and V for dst minus src over W bits.
// Assumes both operands have already been truncated to W bits.
module cmpflag_slice
    import cmpflag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] dst,
    input  logic [W-1:0] src,
    output flagset_t     fl
);
    logic [W-1:0] diff;

    // Difference and the four condition bits derived from it.
    always_comb begin
        diff = dst - src;
        fl.z = (diff == '0);
        fl.n = diff[W-1];
        fl.c = (src > dst);
        fl.v = (dst[W-1] != src[W-1]) && (dst[W-1] != diff[W-1]);
    end
endmodule

// File: rtl/cmpflag_unit.sv
// Dual-width compare flag unit (top).
// One subtraction feeds a narrow and a wide flag evaluator. The eight flags
// are packed into a status-word image at parameter positions and registered
// together with a write-enable mask that follows the op_valid strobe.
// Assumes the eight positions are distinct and lie below PSW_W.
module cmpflag_unit
    import cmpflag_pkg::*;
#(
    parameter int REG_W    = 24,
    parameter int NARROW_W = 16,
    parameter int IMM_W    = 16,
    parameter int PSW_W    = 16,
    parameter int ZN_POS   = 0,
    parameter int NN_POS   = 1,
    parameter int CN_POS   = 2,
    parameter int VN_POS   = 3,
    parameter int ZW_POS   = 4,
    parameter int NW_POS   = 5,
    parameter int CW_POS   = 6,
    parameter int VW_POS   = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [1:0]             src_sel,
    input  logic                   dst_is_addr,
    input  logic [REG_W-1:0]       dst_val,
    input  logic [REG_W-1:0]       dreg_val,
    input  logic [REG_W-1:0]       areg_val,
    input  logic [IMM_W-1:0]       imm_field,
    input  logic [REG_W-IMM_W-1:0] imm_ext,
    output logic [PSW_W-1:0]       flags_o,
    output logic [PSW_W-1:0]       flag_we_o
);
    localparam int NUM_SETS = 2;
    localparam logic [PSW_W-1:0] WE_MASK =
        (PSW_W'(1) << ZN_POS) | (PSW_W'(1) << NN_POS) |
        (PSW_W'(1) << CN_POS) | (PSW_W'(1) << VN_POS) |
        (PSW_W'(1) << ZW_POS) | (PSW_W'(1) << NW_POS) |
        (PSW_W'(1) << CW_POS) | (PSW_W'(1) << VW_POS);

    logic [REG_W-1:0] src;
    flagset_t         fs [NUM_SETS];
    logic [PSW_W-1:0] word;

    cmpflag_opsel #(.REG_W(REG_W), .IMM_W(IMM_W)) u_opsel (
        .sel         (src_sel_e'(src_sel)),
        .dst_is_addr (dst_is_addr),
        .dreg_val    (dreg_val),
        .areg_val    (areg_val),
        .imm_field   (imm_field),
        .imm_ext     (imm_ext),
        .src         (src)
    );

    // One evaluator per width: set 0 is narrow, set 1 is wide.
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        localparam int SW = (g == 0) ? NARROW_W : REG_W;
        cmpflag_slice #(.W(SW)) u_slice (
            .dst (dst_val[SW-1:0]),
            .src (src[SW-1:0]),
            .fl  (fs[g])
        );
    end

    // Pack both flag sets into the status-word image.
    always_comb begin
        word         = '0;
        word[ZN_POS] = fs[0].z;
        word[NN_POS] = fs[0].n;
        word[CN_POS] = fs[0].c;
        word[VN_POS] = fs[0].v;
        word[ZW_POS] = fs[1].z;
        word[NW_POS] = fs[1].n;
        word[CW_POS] = fs[1].c;
        word[VW_POS] = fs[1].v;
    end

    // Output register: capture flags on a valid compare, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o   <= '0;
            flag_we_o <= '0;
        end else begin
            flag_we_o <= op_valid ? WE_MASK : '0;
            if (op_valid) flags_o <= word;
        end
    end

    AST_WE_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flag_we_o == WE_MASK)); // R8
    AST_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (flag_we_o == '0)); // R8
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_o)); // R9
    AST_NO_STRAY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ((flags_o & ~WE_MASK) == '0)); // R9
    AST_WIDE_ZERO_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && fs[1].z) |-> fs[0].z); // R1
endmodule

// File: tb/cmpflag_unit_bench.sv
module cmpflag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  src_sel = '0;
    logic        dst_is_addr = 1'b0;
    logic [23:0] dst_val = '0, dreg_val = '0, areg_val = '0;
    logic [15:0] imm_field = '0;
    logic [7:0]  imm_ext = '0;
    logic [15:0] flags_o, flag_we_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cmpflag_unit u_cmpflag_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .src_sel(src_sel),
        .dst_is_addr(dst_is_addr), .dst_val(dst_val), .dreg_val(dreg_val),
        .areg_val(areg_val), .imm_field(imm_field), .imm_ext(imm_ext),
        .flags_o(flags_o), .flag_we_o(flag_we_o)
    );

    localparam logic [23:0] VALS [10] = '{24'h000000, 24'h000001, 24'h007FFF,
        24'h008000, 24'h00FFFF, 24'h010000, 24'h7FFFFF, 24'h800000,
        24'hFFFFFF, 24'h12FFFF};
    localparam logic [15:0] IMMS [5] = '{16'h0000, 16'h0001, 16'h7FFF,
        16'h8000, 16'hFFFF};

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Expected status word with default positions (R11).
    function automatic logic [15:0] expect_word(input logic [23:0] d, input logic [23:0] s);
        logic [23:0] df;
        logic [15:0] w;
        df = d - s;
        w = '0;
        w[0] = (df[15:0] == 16'h0);
        w[1] = df[15];
        w[2] = (s[15:0] > d[15:0]);
        w[3] = (d[15] != s[15]) && (d[15] != df[15]);
        w[4] = (df == 24'h0);
        w[5] = df[23];
        w[6] = (s > d);
        w[7] = (d[23] != s[23]) && (d[23] != df[23]);
        return w;
    endfunction

    task automatic do_op(input string tag, input logic [1:0] sel, input logic isaddr,
                         input logic [23:0] d, input logic [23:0] exp_src,
                         input logic [23:0] dr, input logic [23:0] ar,
                         input logic [15:0] fld, input logic [7:0] ext);
        logic [15:0] e;
        logic [15:0] held;
        e = expect_word(d, exp_src);
        @(negedge clk);
        op_valid = 1'b1; src_sel = sel; dst_is_addr = isaddr; dst_val = d;
        dreg_val = dr; areg_val = ar; imm_field = fld; imm_ext = ext;
        @(negedge clk);
        op_valid = 1'b0;
        chk({tag, " word"}, flags_o, e);
        chk("R1 zero", flags_o & 16'h0011, e & 16'h0011);
        chk("R2 negative", flags_o & 16'h0022, e & 16'h0022);
        chk("R3 carry", flags_o & 16'h0044, e & 16'h0044);
        chk("R4 overflow", flags_o & 16'h0088, e & 16'h0088);
        chk("R8 we valid", flag_we_o, 16'h00FF);
        held = flags_o;
        dst_val = ~d; dreg_val = ~dr; areg_val = ~ar; src_sel = ~sel;
        imm_field = ~fld; dst_is_addr = ~isaddr;
        @(negedge clk);
        chk("R9 hold", flags_o, held);
        chk("R8 we idle", flag_we_o, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset flags", flags_o, 16'h0);
        chk("R10 reset we", flag_we_o, 16'h0);
        rst_n = 1'b1;
        // R5: register sources, with the unselected register holding other data.
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++) begin
                do_op("R5 dreg", 2'd0, j[0], VALS[i], VALS[j], VALS[j], ~VALS[j], 16'h5A5A, 8'hC3);
                do_op("R5 areg", 2'd1, j[0], VALS[i], VALS[j], ~VALS[j], VALS[j], 16'hA5A5, 8'h3C);
            end
        // R6: imm16 sign-extended for data targets, zero-extended for address targets.
        for (int i = 0; i < 10; i++)
            for (int k = 0; k < 5; k++) begin
                do_op("R6 imm16 data", 2'd2, 1'b0, VALS[i],
                      {{8{IMMS[k][15]}}, IMMS[k]}, 24'h111111, 24'h222222, IMMS[k], 8'hEE);
                do_op("R6 imm16 addr", 2'd2, 1'b1, VALS[i],
                      {8'h00, IMMS[k]}, 24'h111111, 24'h222222, IMMS[k], 8'hEE);
            end
        // R7: imm24 assembled from the field and the extension byte.
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                do_op("R7 imm24", 2'd3, j[1], VALS[i], VALS[j], 24'h333333, 24'h444444,
                      VALS[j][23:8], VALS[j][7:0]);
        // R10: reset in mid-run clears the outputs.
        @(negedge clk);
        op_valid = 1'b1; dst_val = 24'h0; src_sel = 2'd0; dreg_val = 24'h1;
        rst_n = 1'b0;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R10 reset flags mid", flags_o, 16'h0);
        chk("R10 reset we mid", flag_we_o, 16'h0);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule